// File: doc/BRIEF.md
# Register-Mapped Serial Port with Parity and Handshake

This block is a serial transmitter/receiver that a processor reaches through two 32-bit word registers on a simple synchronous bus. The control word at byte offset 0x00 sets the bit rate, the parity mode, the two handshake enables and a global enable. It also reports whether the transmitter is busy. The data word at byte offset 0x04 starts a transmission when written. When read, it returns the last received byte together with four flags, and the read clears those flags.

Frames always carry one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The bit period is formed from a coarse power-of-two ladder and a 12-bit fine count. Two interrupt lines tell software when a transmission has finished and when a byte has arrived. Bus reads are combinational in the cycle the bus selects the block. Writes and read side effects take effect at the clock edge that ends that cycle.

Top module: `mmio_uart`

## Requirements
- R1: After reset both registers read as zero, the port is disabled, txOut is high, rtsN is low and both interrupt lines are low.
- R2: The control word keeps bits [11:0], [26:20] and 28 as written and reads every other bit as zero. Bit 31 reads as 1 exactly while a transmission is pending or in progress, and writes to it have no effect.
- R3: One bit lasts (F+1) x 2 x D clock cycles. F is control bits [11:0]. D is 2, 4, 8, 64, 128, 1024, 2048 or 4096 for control bits [26:24] = 0..7.
- R4: While control bit 28 is 0, the transmitter and receiver stay idle and data writes start nothing. The other control fields are kept and read back unchanged.
- R5: The edge after an accepted data write marks the frame as pending. The next edge starts the start bit (low). Data bits [7:0] follow LSB first, then a parity bit when control bits [23:22] are 10 (even) or 11 (odd), then one high stop bit. Codes 01 and 00 send no parity bit.
- R6: A data-word read returns the byte in [7:0], parity error in bit 28, framing error in bit 29, overrun in bit 30 and byte-available in bit 31, with all other bits zero. The edge that ends the read clears all four flags.
- R7: The rxIn line is sampled after a two-stage synchronizer, in the middle of each bit. A stored byte sets bit 31 of the data word, and irqRx is high for exactly that one cycle.
- R8: irqTx pulses high for one cycle, in the first cycle after the stop bit, when the busy flag is already low.
- R9: When control bit 21 is 1, a pending frame does not start while ctsN is high. It starts once ctsN has been low through the synchronizer. Busy stays high while the frame waits.
- R10: A data write while busy is ignored. The frame in progress continues unchanged and no extra frame follows.
- R11: A received parity mismatch sets bit 28. A low stop bit sets bit 29. A byte that completes while bit 31 is still set sets bit 30 and replaces the stored byte.
- R12: A low pulse on rxIn that is high again at the middle of the start bit stores nothing and raises no interrupt.
- R13: When control bit 20 is 1, rtsN is high exactly while bit 31 of the data word is set. When control bit 20 is 0, rtsN stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (4) | Byte address; 0x0 control, 0x4 data |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle busSel is high |
| txOut | output | 1 | Serial transmit line, idle high |
| rxIn | input | 1 | Serial receive line, asynchronous |
| ctsN | input | 1 | Clear-to-send, active low, asynchronous |
| rtsN | output | 1 | Request-to-send, active low |
| irqTx | output | 1 | Transmission-finished pulse |
| irqRx | output | 1 | Byte-received pulse |

## Verification
Properties watch the relationships that must hold on every edge. A load is never issued while the transmitter is busy. The finish pulse lasts one cycle and never overlaps busy. A frame blocked by the handshake stays parked. Reading the data word clears every flag. Storing a byte raises the flag, the byte and the interrupt together, and a completion while the flag is still set records an overrun. The bench compares the transmit line and the finish pulse on every clock with a queue-based model of the frame timing. The correct bit lengths for several ladder settings, the parity values, the rejection of a false start and the exact flag words after parity, framing and overrun events can only be shown by the bench's directed frames.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
  localparam int FINE_W = 12;
  localparam int SEL_W  = 3;
  localparam int LEN_W  = FINE_W + 14;   // (fine+1) << (12+1)

  localparam int EN_BIT     = 28;
  localparam int CTS_BIT    = 21;
  localparam int RTS_BIT    = 20;
  localparam int PAR_ON_BIT = 23;
  localparam int PAR_ODD_BIT = 22;
  localparam int SEL_LO     = 24;
  localparam logic [31:0] CTRL_MASK = 32'h17F0_0FFF;

  typedef struct packed {
    logic             en;
    logic             parEn;
    logic             parOdd;
    logic             ctsEn;
    logic [LEN_W-1:0] bitLen;
  } uartCfg_t;

  typedef struct packed {
    logic       txLoad;
    logic [7:0] txByte;
  } uartStb_t;

  typedef struct packed {
    logic       valid;
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } rxEvt_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_t;

  // log2 of the coarse divider for each select value
  function automatic logic [3:0] ladderShift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: ladderShift = 4'd1;
      3'd1: ladderShift = 4'd2;
      3'd2: ladderShift = 4'd3;
      3'd3: ladderShift = 4'd6;
      3'd4: ladderShift = 4'd7;
      3'd5: ladderShift = 4'd10;
      3'd6: ladderShift = 4'd11;
      default: ladderShift = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/mmio_uart_ctrl.sv
module mmio_uart_ctrl
  import mmio_uart_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              txBusy,
  input  rxEvt_t            rxEvt,
  output uartCfg_t          cfg,
  output uartStb_t          stb,
  output logic              rtsN,
  output logic              irqRx
);
  localparam int WSEL_W = ADDR_W - 2;

  logic [31:0] ctrlQ;
  logic [7:0]  rxByte;
  logic        avail, ovr, ferr, perr;
  logic        aligned, isCtrl, isData, dataRd;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign isCtrl  = busSel && aligned && (busAddr[ADDR_W-1:2] == WSEL_W'(0));
  assign isData  = busSel && aligned && (busAddr[ADDR_W-1:2] == WSEL_W'(1));
  assign dataRd  = isData && !busWe;

  always_comb begin
    cfg.en     = ctrlQ[EN_BIT];
    cfg.parEn  = ctrlQ[PAR_ON_BIT];
    cfg.parOdd = ctrlQ[PAR_ODD_BIT];
    cfg.ctsEn  = ctrlQ[CTS_BIT];
    cfg.bitLen = (LEN_W'(ctrlQ[FINE_W-1:0]) + LEN_W'(1))
                 << (ladderShift(ctrlQ[SEL_LO +: SEL_W]) + 4'd1);
  end

  assign stb.txLoad = isData && busWe && ctrlQ[EN_BIT] && !txBusy;
  assign stb.txByte = busWdata[7:0];
  assign rtsN       = ctrlQ[RTS_BIT] && avail;

  always_comb begin
    busRdata = '0;
    if (isCtrl)      busRdata = {ctrlQ[31] | txBusy, ctrlQ[30:0]};
    else if (isData) busRdata = {avail, ovr, ferr, perr, 20'd0, rxByte};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      rxByte <= '0;
      avail  <= 1'b0;
      ovr    <= 1'b0;
      ferr   <= 1'b0;
      perr   <= 1'b0;
      irqRx  <= 1'b0;
    end else begin
      if (isCtrl && busWe) ctrlQ <= busWdata & CTRL_MASK;
      avail <= (avail && !dataRd) || rxEvt.valid;
      ovr   <= (ovr && !dataRd) || (rxEvt.valid && avail && !dataRd);
      ferr  <= (ferr && !dataRd) || (rxEvt.valid && rxEvt.ferr);
      perr  <= (perr && !dataRd) || (rxEvt.valid && rxEvt.perr);
      irqRx <= rxEvt.valid;
      if (rxEvt.valid) rxByte <= rxEvt.data;
    end
  end

  // R6: a data read without a simultaneous arrival leaves every flag clear
  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !rxEvt.valid) |=> (!avail && !ovr && !ferr && !perr));

  // R7: an arriving byte is stored, flagged and signalled together
  p_rx_store_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxEvt.valid |=> (avail && irqRx && rxByte == $past(rxEvt.data)));

  // R11: completion on top of unread data records an overrun
  p_overrun_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxEvt.valid && avail && !dataRd) |=> ovr);

  // R4: a port disabled for two cycles has an idle transmitter
  p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[EN_BIT] && !$past(ctrlQ[EN_BIT])) |-> !txBusy);
endmodule

// File: rtl/mmio_uart_dp.sv
module mmio_uart_dp
  import mmio_uart_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  uartCfg_t cfg,
  input  uartStb_t stb,
  input  logic     ctsN,
  input  logic     rxIn,
  output logic     txOut,
  output logic     txBusy,
  output logic     irqTx,
  output rxEvt_t   rxEvt
);
  // ---------------- transmitter ----------------
  logic             txWait, txActive;
  logic [10:0]      txSh;
  logic [3:0]       txLeft;
  logic [LEN_W-1:0] txCnt;
  logic             ctsF1, ctsF2;
  logic             txPar;

  assign txPar  = (^stb.txByte) ^ cfg.parOdd;
  assign txBusy = txWait || txActive;
  assign txOut  = txActive ? txSh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWait <= 1'b0; txActive <= 1'b0; txSh <= '1; txLeft <= '0;
      txCnt <= '0; irqTx <= 1'b0; ctsF1 <= 1'b1; ctsF2 <= 1'b1;
    end else begin
      ctsF1 <= ctsN;
      ctsF2 <= ctsF1;
      irqTx <= 1'b0;
      if (!cfg.en) begin
        txWait   <= 1'b0;
        txActive <= 1'b0;
      end else if (stb.txLoad) begin
        txWait <= 1'b1;
        txSh   <= cfg.parEn ? {1'b1, txPar, stb.txByte, 1'b0}
                            : {2'b11, stb.txByte, 1'b0};
        txLeft <= cfg.parEn ? 4'd11 : 4'd10;
      end else if (txWait) begin
        if (!cfg.ctsEn || !ctsF2) begin
          txWait   <= 1'b0;
          txActive <= 1'b1;
          txCnt    <= '0;
        end
      end else if (txActive) begin
        if (txCnt == cfg.bitLen - LEN_W'(1)) begin
          txCnt  <= '0;
          txSh   <= {1'b1, txSh[10:1]};
          txLeft <= txLeft - 4'd1;
          if (txLeft == 4'd1) begin
            txActive <= 1'b0;
            irqTx    <= 1'b1;
          end
        end else begin
          txCnt <= txCnt + LEN_W'(1);
        end
      end
    end
  end

  // ---------------- receiver ----------------
  rxState_t         rxState;
  logic             rxF1, rxF2, rxPrev;
  logic [LEN_W-1:0] rxCnt;
  logic [3:0]       rxIdx;
  logic [7:0]       rxData;
  logic             rxParBit;
  logic [LEN_W-1:0] halfLen;

  assign halfLen = cfg.bitLen >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE; rxF1 <= 1'b1; rxF2 <= 1'b1; rxPrev <= 1'b1;
      rxCnt <= '0; rxIdx <= '0; rxData <= '0; rxParBit <= 1'b0; rxEvt <= '0;
    end else begin
      rxF1   <= rxIn;
      rxF2   <= rxF1;
      rxPrev <= rxF2;
      rxEvt.valid <= 1'b0;
      if (!cfg.en) begin
        rxState <= RX_IDLE;
      end else begin
        case (rxState)
          RX_IDLE: if (rxPrev && !rxF2) begin
            rxState <= RX_START;
            rxCnt   <= '0;
          end
          RX_START: if (rxCnt == halfLen - LEN_W'(1)) begin
            rxCnt   <= '0;
            rxIdx   <= '0;
            rxState <= rxF2 ? RX_IDLE : RX_BITS;
          end else begin
            rxCnt <= rxCnt + LEN_W'(1);
          end
          RX_BITS: if (rxCnt == cfg.bitLen - LEN_W'(1)) begin
            rxCnt <= '0;
            rxIdx <= rxIdx + 4'd1;
            if (rxIdx < 4'd8) rxData[rxIdx[2:0]] <= rxF2;
            else if (cfg.parEn && rxIdx == 4'd8) rxParBit <= rxF2;
            if (rxIdx == (cfg.parEn ? 4'd9 : 4'd8)) begin
              rxState    <= RX_IDLE;
              rxEvt.valid <= 1'b1;
              rxEvt.data <= rxData;
              rxEvt.ferr <= !rxF2;
              rxEvt.perr <= cfg.parEn && (rxParBit != ((^rxData) ^ cfg.parOdd));
            end
          end else begin
            rxCnt <= rxCnt + LEN_W'(1);
          end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  // R10: the control side never loads a busy transmitter
  p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.txLoad |-> !txBusy);

  // R8: the finish pulse is single and only seen when idle
  p_txirq_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqTx |=> !irqTx);
  p_txirq_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqTx |-> !txBusy);

  // R9: a parked frame stays parked while the handshake is withheld
  p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && txWait && cfg.ctsEn && ctsF2) |=> (txWait && !txActive));
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txOut,
  input  logic              rxIn,
  input  logic              ctsN,
  output logic              rtsN,
  output logic              irqTx,
  output logic              irqRx
);
  uartCfg_t cfg;
  uartStb_t stb;
  rxEvt_t   rxEvt;
  logic     txBusy;

  mmio_uart_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txBusy(txBusy), .rxEvt(rxEvt),
    .cfg(cfg), .stb(stb), .rtsN(rtsN), .irqRx(irqRx)
  );

  mmio_uart_dp dp_i (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .ctsN(ctsN), .rxIn(rxIn),
    .txOut(txOut), .txBusy(txBusy), .irqTx(irqTx), .rxEvt(rxEvt)
  );
endmodule

// File: tb/mmio_uart_tb_top.sv
`timescale 1ns/1ps
module mmio_uart_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txOut, rtsN, irqTx, irqRx;
  logic        rxIn = 1'b1, ctsN = 1'b0;

  int nVec = 0, nMiss = 0, irqRxCnt = 0;

  mmio_uart dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txOut(txOut), .rxIn(rxIn),
    .ctsN(ctsN), .rtsN(rtsN), .irqTx(irqTx), .irqRx(irqRx)
  );

  always #4 clk = ~clk;

  // ---------------- behavioural transmit model ----------------
  int  txQ[$];          // expected line level per cycle; 2 = pending slot
  bit  enM = 0, ctsEnM = 0, parEnM = 0, parOddM = 0;
  int  bitLenM = 4;
  bit  irqExp = 0;
  bit  ctsD1 = 1, ctsD2 = 1;

  function automatic int ladder(input int sel);
    int div = 2;
    if (sel == 1) div = 4;
    if (sel == 2) div = 8;
    if (sel == 3) div = 64;
    if (sel == 4) div = 128;
    if (sel == 5) div = 1024;
    if (sel == 6) div = 2048;
    if (sel == 7) div = 4096;
    return div;
  endfunction

  task automatic pushBit(input int v);
    for (int k = 0; k < bitLenM; k++) txQ.push_back(v);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      txQ.delete(); irqExp = 0; enM = 0; ctsEnM = 0; parEnM = 0; parOddM = 0;
      ctsD1 = 1; ctsD2 = 1;
    end else begin
      bit wasBusy;
      wasBusy = (txQ.size() != 0);
      irqExp = 0;
      if (txQ.size() != 0) begin
        if (txQ[0] == 2) begin
          if (!ctsEnM || !ctsD2) void'(txQ.pop_front());
        end else begin
          void'(txQ.pop_front());
          if (txQ.size() == 0) irqExp = 1;
        end
      end
      ctsD2 = ctsD1;
      ctsD1 = ctsN;
      if (busSel && busWe && busAddr == 4'h0) begin
        enM     = busWdata[28];
        ctsEnM  = busWdata[21];
        parEnM  = busWdata[23];
        parOddM = busWdata[22];
        bitLenM = (int'(busWdata[11:0]) + 1) * 2 * ladder(int'(busWdata[26:24]));
      end else if (busSel && busWe && busAddr == 4'h4 && enM && !wasBusy) begin
        txQ.push_back(2);
        pushBit(0);
        for (int i = 0; i < 8; i++) pushBit(int'(busWdata[i]));
        if (parEnM) pushBit(int'((^busWdata[7:0]) ^ parOddM));
        pushBit(1);
      end
    end
  end

  // per-cycle comparison of the line and the finish pulse
  always @(negedge clk) begin
    if (rstN) begin
      int expLine;
      expLine = (txQ.size() == 0 || txQ[0] == 2) ? 1 : txQ[0];
      nVec++;
      if (txOut !== expLine[0] || irqTx !== irqExp) begin
        nMiss++;
        $display("FAIL R5/R8 t=%0t txOut=%b irqTx=%b expected txOut=%b irqTx=%b",
                 $time, txOut, irqTx, expLine[0], irqExp);
      end
      if (irqRx) irqRxCnt++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nMiss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busSel = 0; busWe = 0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    busSel = 1; busWe = 0; busAddr = a;
    @(negedge clk); d = busRdata;
    @(posedge clk); #2;
    busSel = 0;
  endtask

  task automatic waitTxIdle();
    while (txQ.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic holdRx(input logic v);
    rxIn = v;
    repeat (bitLenM) @(posedge clk);
    #2;
  endtask

  task automatic sendRx(input logic [7:0] b, input bit withPar, input logic parBit,
                        input logic stopBit);
    @(posedge clk); #2;
    holdRx(1'b0);
    for (int i = 0; i < 8; i++) holdRx(b[i]);
    if (withPar) holdRx(parBit);
    holdRx(stopBit);
    rxIn = 1'b1;
    repeat (2 * bitLenM) @(posedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nVec++; nMiss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0] rd;
    int irqBefore;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 txOut in reset", {31'd0, txOut}, 32'd1);
    #2 rstN = 1'b1;

    // R1: reset values
    busRead(4'h0, rd); chk("R1 control after reset", rd, 32'h0);
    busRead(4'h4, rd); chk("R1 data after reset", rd, 32'h0);
    chk("R1 rtsN/irq after reset", {29'd0, rtsN, irqTx, irqRx}, 32'h0);

    // R2: writable field mask
    busWrite(4'h0, 32'hFFFF_FFFF);
    busRead(4'h0, rd); chk("R2 control mask", rd, 32'h17F0_0FFF);

    // R5: no parity, 16-cycle bits; R2 busy bit; R10 write while busy
    busWrite(4'h0, 32'h1040_0003);
    busWrite(4'h4, 32'h0000_00A5);
    busRead(4'h0, rd); chk("R2 busy bit during frame", rd, 32'h9040_0003);
    busWrite(4'h4, 32'h0000_003C);   // R10: must be ignored
    waitTxIdle();
    busRead(4'h0, rd); chk("R2 busy clear after frame", rd, 32'h1040_0003);

    // R3: other ladder settings, with even and odd parity (R5)
    busWrite(4'h0, 32'h1180_0002);   // divider 4, fine 2 -> 24 cycles, even
    busWrite(4'h4, 32'h0000_0081);
    waitTxIdle();
    busWrite(4'h0, 32'h13C0_0000);   // divider 64, fine 0 -> 128 cycles, odd
    busWrite(4'h4, 32'h0000_0007);
    waitTxIdle();

    // R9: frame parked while ctsN high
    ctsN = 1'b1;
    busWrite(4'h0, 32'h1060_0003);
    busWrite(4'h4, 32'h0000_0055);
    repeat (40) @(posedge clk);
    busRead(4'h0, rd); chk("R9 busy while waiting on handshake", rd, 32'h9060_0003);
    chk("R9 line idle while waiting", {31'd0, txOut}, 32'd1);
    #2 ctsN = 1'b0;
    waitTxIdle();

    // R7, R13: receive a byte with RTS enabled
    busWrite(4'h0, 32'h1050_0003);
    chk("R13 rtsN low with nothing pending", {31'd0, rtsN}, 32'd0);
    irqBefore = irqRxCnt;
    sendRx(8'h5A, 0, 1'b0, 1'b1);
    chk("R7 one receive pulse", irqRxCnt - irqBefore, 32'd1);
    chk("R13 rtsN high while unread", {31'd0, rtsN}, 32'd1);
    busRead(4'h4, rd); chk("R6 data word with byte", rd, 32'h8000_005A);
    chk("R13 rtsN low after read", {31'd0, rtsN}, 32'd0);
    busRead(4'h4, rd); chk("R6 flags cleared by read", rd, 32'h0000_005A);

    // R11: overrun keeps the newer byte
    sendRx(8'h11, 0, 1'b0, 1'b1);
    sendRx(8'h22, 0, 1'b0, 1'b1);
    busRead(4'h4, rd); chk("R11 overrun word", rd, 32'hC000_0022);

    // R11: parity mismatch, then low stop bit, under even parity
    busWrite(4'h0, 32'h1090_0003);
    sendRx(8'h03, 1, 1'b1, 1'b1);
    busRead(4'h4, rd); chk("R11 parity error word", rd, 32'h9000_0003);
    sendRx(8'h44, 1, 1'b0, 1'b0);
    busRead(4'h4, rd); chk("R11 framing error word", rd, 32'hA000_0044);
    sendRx(8'hC3, 1, 1'b0, 1'b1);
    busRead(4'h4, rd); chk("R11 clean frame after errors", rd, 32'h8000_00C3);

    // R12: short glitch is rejected
    irqBefore = irqRxCnt;
    @(posedge clk); #2 rxIn = 1'b0;
    repeat (3) @(posedge clk);
    #2 rxIn = 1'b1;
    repeat (12 * bitLenM) @(posedge clk);
    chk("R12 no pulse for false start", irqRxCnt - irqBefore, 32'd0);
    busRead(4'h4, rd); chk("R12 nothing stored", rd, 32'h0000_00C3);

    // R4: disabled port keeps settings and does nothing
    busWrite(4'h0, 32'h0050_0003);
    busRead(4'h0, rd); chk("R4 settings kept while disabled", rd, 32'h0050_0003);
    busWrite(4'h4, 32'h0000_0099);
    repeat (20) @(posedge clk);
    busRead(4'h0, rd); chk("R4 no busy while disabled", rd, 32'h0050_0003);
    sendRx(8'h66, 0, 1'b0, 1'b1);
    busRead(4'h4, rd); chk("R4 receiver idle while disabled", rd, 32'h0000_00C3);
    busWrite(4'h0, 32'h1050_0003);
    busWrite(4'h4, 32'h0000_00F0);
    waitTxIdle();

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end
endmodule